// File: doc/BRIEF.md
# Nibble-Wide Strobed Port Expander

This block adds four 4-bit peripheral ports to a host that has only a narrow link. The link is one 4-bit bidirectional control bus, one strobe line and an active-low chip select. Each transfer uses both edges of the strobe. The falling edge carries a command nibble that names a port and an operation. The rising edge completes that operation. For a write-type operation, the host places data on the bus before the rising edge. For a read, the block drives the selected port's pin value onto the bus while the strobe is low.

There are three write-type operations: direct load, OR-merge and AND-merge. Each combines the bus nibble with the port's output latch and then turns the port's driver on. A read turns the selected port's driver off, so the port behaves as an input. The port stays released after the read. Every pad is split into separate in, out and enable signals.

The strobe and chip select are asynchronous to the system clock. Both pass through a synchronizer, and the strobe edges are detected after it. The bus and pin inputs are sampled directly, so they must be stable around each strobe edge.

Top module: `nibble_port_expander`

## Requirements
- R1: A synchronous active-high reset sets every output latch to 0, clears every port enable and releases the control bus. The reset takes effect at the first clock edge and discards any transfer that is in progress.
- R2: The nibble on `bus_in` at the strobe's falling edge is the command. Bits [1:0] select the port (0 to 3). Bits [3:2] select the operation: 00 read, 01 direct load, 10 OR-merge, 11 AND-merge.
- R3: On the rising edge after a direct-load command, the selected port's latch takes the `bus_in` nibble and its enable goes high. No other port changes.
- R4: On the rising edge after an OR-merge command, the selected latch becomes its previous value ORed with `bus_in`, and its enable goes high.
- R5: On the rising edge after an AND-merge command, the selected latch becomes its previous value ANDed with `bus_in`, and its enable goes high.
- R6: A port whose enable is high keeps driving its latch value, unchanged, until a later write-type operation on that port changes it or a read of that port releases it.
- R7: After a read command is captured, `bus_oe` is high and `bus_out` shows the selected port's `port_in` nibble until the rising edge. The selected port's enable drops when the command is captured and stays low after the read. Its latch value is kept. At all other times `bus_oe` is low.
- R8: While `cs_n` is high, strobe edges are ignored. No latch, enable or stored command changes, and `bus_oe` stays low.
- R9: A rising edge that has no falling edge captured with chip select active before it has no effect on any port.
- R10: The strobe and chip select each pass through a two-stage synchronizer. A strobe transition becomes visible at the outputs after the third rising clock edge following it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strb | input | 1 | Transfer strobe, asynchronous; its falling edge carries the command and its rising edge the data |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_in | input | 4 | Control bus pad input: command or data |
| bus_out | output | 4 | Control bus pad output: read data |
| bus_oe | output | 1 | Control bus pad enable |
| port_in | input | 16 | Pin values of the four peripheral ports, port p in bits [4p+3:4p] |
| port_out | output | 16 | Output latches of the four ports, same layout as `port_in` |
| port_oe | output | 4 | Per-port driver enable, bit p for port p |

## Verification
The latches and enables are outputs, so a corrupted latch or an enable that drops by mistake shows up at the pads in the same cycle the register changes. That is three clock edges after the strobe edge responsible for it. The stored command and the armed flag are hidden. Their faults show up only at the next rising edge: the wrong port changes, the wrong merge is applied, or an unarmed rising edge takes effect. A stale read phase shows up as `bus_oe` still high after the strobe has risen.

// File: rtl/pex_pkg.sv
package pex_pkg;

  // Layout of the command nibble: {operation[1:0], port[1:0]}
  localparam int PEX_NIB    = 4;
  localparam int PEX_ADDR_W = 2;
  localparam int PEX_PORTS  = 1 << PEX_ADDR_W;
  localparam int PEX_OP_W   = PEX_NIB - PEX_ADDR_W;

  typedef enum logic [PEX_OP_W-1:0] {
    OP_READ = 2'b00,
    OP_LOAD = 2'b01,
    OP_SET  = 2'b10,
    OP_MASK = 2'b11
  } pex_op_e;

  function automatic logic [PEX_ADDR_W-1:0] pex_cmd_port(input logic [PEX_NIB-1:0] cmd);
    return cmd[PEX_ADDR_W-1:0];
  endfunction

  function automatic pex_op_e pex_cmd_op(input logic [PEX_NIB-1:0] cmd);
    return pex_op_e'(cmd[PEX_NIB-1:PEX_ADDR_W]);
  endfunction

  // New latch value produced by a write-type operation
  function automatic logic [PEX_NIB-1:0] pex_merge(input pex_op_e op,
                                                   input logic [PEX_NIB-1:0] old_val,
                                                   input logic [PEX_NIB-1:0] bus_val);
    logic [PEX_NIB-1:0] res;
    case (op)
      OP_SET:  res = old_val | bus_val;
      OP_MASK: res = old_val & bus_val;
      OP_LOAD: res = bus_val;
      default: res = old_val;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pex_sync.sv
module pex_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic ff;
      always_ff @(posedge clk) begin
        if (rst) ff <= RST_VAL;
        else     ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pex_seq.sv
module pex_seq
  import pex_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strb_s,
  input  logic                  cs_act,
  input  logic [PEX_NIB-1:0]    bus_in,
  output logic                  evt_fall,
  output logic                  evt_rise,
  output logic                  armed,
  output logic                  read_open,
  output logic [PEX_ADDR_W-1:0] cmd_addr,
  output pex_op_e               cmd_op,
  output logic                  apply_wr,
  output logic                  rel_rd,
  output logic [PEX_ADDR_W-1:0] rel_addr
);
  logic               strb_prev;
  logic [PEX_NIB-1:0] cmd_q;
  logic               take_cmd;
  logic               fire;

  assign evt_fall = strb_prev & ~strb_s;
  assign evt_rise = ~strb_prev & strb_s;
  assign take_cmd = evt_fall & cs_act;
  assign fire     = evt_rise & cs_act & armed;

  assign cmd_addr = pex_cmd_port(cmd_q);
  assign cmd_op   = pex_cmd_op(cmd_q);
  assign apply_wr = fire && (cmd_op != OP_READ);
  assign rel_rd   = take_cmd && (pex_cmd_op(bus_in) == OP_READ);
  assign rel_addr = pex_cmd_port(bus_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_prev <= 1'b1;
      cmd_q     <= '0;
      armed     <= 1'b0;
      read_open <= 1'b0;
    end else begin
      strb_prev <= strb_s;
      if (take_cmd) begin
        cmd_q     <= bus_in;
        armed     <= 1'b1;
        read_open <= (pex_cmd_op(bus_in) == OP_READ);
      end else if (fire) begin
        armed     <= 1'b0;
        read_open <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pex_port_bank.sv
module pex_port_bank
  import pex_pkg::*;
#(
  parameter int NPORTS = PEX_PORTS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      apply_wr,
  input  pex_op_e                   wr_op,
  input  logic [PEX_ADDR_W-1:0]     wr_addr,
  input  logic [PEX_NIB-1:0]        wr_data,
  input  logic                      rel_rd,
  input  logic [PEX_ADDR_W-1:0]     rel_addr,
  output logic [NPORTS*PEX_NIB-1:0] port_out,
  output logic [NPORTS-1:0]         port_oe
);
  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [PEX_NIB-1:0] lat;
      logic               drv;
      always_ff @(posedge clk) begin
        if (rst) begin
          lat <= '0;
          drv <= 1'b0;
        end else if (apply_wr && (wr_addr == PEX_ADDR_W'(p))) begin
          lat <= pex_merge(wr_op, lat, wr_data);
          drv <= 1'b1;
        end else if (rel_rd && (rel_addr == PEX_ADDR_W'(p))) begin
          drv <= 1'b0;
        end
      end
      assign port_out[p*PEX_NIB +: PEX_NIB] = lat;
      assign port_oe[p]                     = drv;
    end
  endgenerate
endmodule

// File: rtl/nibble_port_expander.sv
module nibble_port_expander
  import pex_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         strb,
  input  logic                         cs_n,
  input  logic [PEX_NIB-1:0]           bus_in,
  output logic [PEX_NIB-1:0]           bus_out,
  output logic                         bus_oe,
  input  logic [PEX_PORTS*PEX_NIB-1:0] port_in,
  output logic [PEX_PORTS*PEX_NIB-1:0] port_out,
  output logic [PEX_PORTS-1:0]         port_oe
);
  logic                  strb_s;
  logic                  cs_n_s;
  logic                  cs_act;
  logic                  evt_fall;
  logic                  evt_rise;
  logic                  armed;
  logic                  read_open;
  logic [PEX_ADDR_W-1:0] cmd_addr;
  pex_op_e               cmd_op;
  logic                  apply_wr;
  logic                  rel_rd;
  logic [PEX_ADDR_W-1:0] rel_addr;

  pex_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_strb (
    .clk(clk), .rst(rst), .d(strb), .q(strb_s)
  );
  pex_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_n_s)
  );
  assign cs_act = ~cs_n_s;

  pex_seq i_seq (
    .clk(clk), .rst(rst), .strb_s(strb_s), .cs_act(cs_act), .bus_in(bus_in),
    .evt_fall(evt_fall), .evt_rise(evt_rise), .armed(armed), .read_open(read_open),
    .cmd_addr(cmd_addr), .cmd_op(cmd_op), .apply_wr(apply_wr),
    .rel_rd(rel_rd), .rel_addr(rel_addr)
  );

  pex_port_bank #(.NPORTS(PEX_PORTS)) i_bank (
    .clk(clk), .rst(rst), .apply_wr(apply_wr), .wr_op(cmd_op), .wr_addr(cmd_addr),
    .wr_data(bus_in), .rel_rd(rel_rd), .rel_addr(rel_addr),
    .port_out(port_out), .port_oe(port_oe)
  );

  assign bus_oe  = read_open & cs_act;
  assign bus_out = bus_oe ? port_in[cmd_addr*PEX_NIB +: PEX_NIB] : '0;
endmodule

// File: rtl/pex_checker.sv
module pex_checker
  import pex_pkg::*;
(
  input logic                         clk,
  input logic                         rst,
  input logic                         cs_act,
  input logic                         evt_rise,
  input logic                         armed,
  input logic                         apply_wr,
  input logic [PEX_ADDR_W-1:0]        cmd_addr,
  input logic                         bus_oe,
  input logic [PEX_PORTS*PEX_NIB-1:0] port_out,
  input logic [PEX_PORTS-1:0]         port_oe
);
  logic past_valid;
  always_ff @(posedge clk) begin
    if (rst) past_valid <= 1'b0;
    else     past_valid <= 1'b1;
  end

  // An enable may only come on because of a write-type operation
  assert_enable_by_write_R3: assert property (@(posedge clk) disable iff (rst)
    (past_valid && ((port_oe & ~$past(port_oe)) != '0)) |-> $past(apply_wr));

  // At most one port changes its enable per cycle
  assert_single_port_R3: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> ($countones(port_oe ^ $past(port_oe)) <= 1));

  // Latches hold unless a write was applied
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(apply_wr)) |-> $stable(port_out));

  // While the bus is driven, the port being read is not
  assert_read_port_released_R7: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !port_oe[cmd_addr]);

  // Bus released after a completed transfer
  assert_bus_release_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_rise && cs_act && armed) |=> !bus_oe);

  // Chip select inactive freezes the ports and keeps the bus released
  assert_cs_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> ($stable(port_out) && $stable(port_oe)));

  assert_cs_bus_off_R8: assert property (@(posedge clk) disable iff (rst)
    !cs_act |-> !bus_oe);

  // A rising edge without a captured command changes nothing
  assert_unarmed_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_rise && !armed) |=> ($stable(port_out) && $stable(port_oe)));
endmodule

bind nibble_port_expander pex_checker i_pex_checker (
  .clk(clk), .rst(rst), .cs_act(cs_act), .evt_rise(evt_rise), .armed(armed),
  .apply_wr(apply_wr), .cmd_addr(cmd_addr), .bus_oe(bus_oe),
  .port_out(port_out), .port_oe(port_oe)
);

// File: tb/test_nibble_port_expander.sv
module test_nibble_port_expander;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;

  typedef struct packed {
    logic [3:0]  ctrl;
    logic [3:0]  data;
    logic [15:0] pins;
    logic [15:0] exp_out;
    logic [3:0]  exp_oe;
    logic [3:0]  exp_rd;
  } vec_t;

  // ctrl = {op, port}: op 00 read, 01 load, 10 OR, 11 AND
  localparam vec_t VECS [NVEC] = '{
    '{4'h4, 4'h5, 16'h0000, 16'h0005, 4'b0001, 4'h0},
    '{4'h6, 4'hA, 16'h0000, 16'h0A05, 4'b0101, 4'h0},
    '{4'h8, 4'h2, 16'h0000, 16'h0A07, 4'b0101, 4'h0},
    '{4'hE, 4'h6, 16'h0000, 16'h0207, 4'b0101, 4'h0},
    '{4'hB, 4'h9, 16'h0000, 16'h9207, 4'b1101, 4'h0},
    '{4'hF, 4'hC, 16'h0000, 16'h8207, 4'b1101, 4'h0},
    '{4'h2, 4'h0, 16'h4B6D, 16'h8207, 4'b1001, 4'hB},
    '{4'h5, 4'hF, 16'h0000, 16'h82F7, 4'b1011, 4'h0},
    '{4'h1, 4'h0, 16'h1234, 16'h82F7, 4'b1001, 4'h3},
    '{4'h4, 4'h0, 16'h0000, 16'h82F0, 4'b1001, 4'h0},
    '{4'h0, 4'h0, 16'hFFFE, 16'h82F0, 4'b1000, 4'hE},
    '{4'h6, 4'h1, 16'h0000, 16'h81F0, 4'b1100, 4'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strb = 1'b1;
  logic        cs_n = 1'b1;
  logic [3:0]  bus_in = '0;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic [15:0] port_in = '0;
  logic [15:0] port_out;
  logic [3:0]  port_oe;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_port_expander i_nibble_port_expander (
    .clk(clk), .rst(rst), .strb(strb), .cs_n(cs_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe_low(input logic [3:0] cmd);
    @(negedge clk);
    bus_in = cmd;
    strb   = 1'b0;
    idle(4);
  endtask

  task automatic strobe_high(input logic [3:0] dat);
    @(negedge clk);
    bus_in = dat;
    strb   = 1'b1;
    idle(4);
  endtask

  initial begin
    idle(3);
    // R1: reset state
    check("R1", "port_out after reset", 32'(port_out), 32'h0);
    check("R1", "port_oe after reset", 32'(port_oe), 32'h0);
    check("R1", "bus_oe after reset", 32'(bus_oe), 32'h0);
    rst  = 1'b0;
    cs_n = 1'b0;
    idle(4);

    // Table walk: R2 decoding, R3/R4/R5 merges, R6 hold, R7 reads
    for (int v = 0; v < NVEC; v++) begin
      port_in = VECS[v].pins;
      strobe_low(VECS[v].ctrl);
      if (VECS[v].ctrl[3:2] == 2'b00) begin
        check("R7", "bus_oe during read", 32'(bus_oe), 32'h1);
        check("R7", "bus_out during read", 32'(bus_out), 32'(VECS[v].exp_rd));
      end else begin
        check("R7", "bus_oe during write", 32'(bus_oe), 32'h0);
      end
      strobe_high(VECS[v].data);
      check("R2", $sformatf("vec %0d port_out (R3 R4 R5 R6)", v),
            32'(port_out), 32'(VECS[v].exp_out));
      check("R2", $sformatf("vec %0d port_oe (R6 R7)", v),
            32'(port_oe), 32'(VECS[v].exp_oe));
      check("R7", $sformatf("vec %0d bus released", v), 32'(bus_oe), 32'h0);
    end

    // R8: chip select inactive, write and read both ignored
    cs_n = 1'b1;
    idle(4);
    strobe_low(4'h4);
    strobe_high(4'hF);
    check("R8", "port_out unchanged, cs high", 32'(port_out), 32'h81F0);
    check("R8", "port_oe unchanged, cs high", 32'(port_oe), 32'hC);
    port_in = 16'hFFFF;
    strobe_low(4'h3);
    check("R8", "bus_oe stays low, cs high", 32'(bus_oe), 32'h0);
    check("R8", "port3 enable kept, cs high", 32'(port_oe), 32'hC);
    // R9: the falling edge above was ignored; the rise comes with cs active
    cs_n = 1'b0;
    idle(4);
    strobe_high(4'hF);
    check("R9", "unarmed rise port_out", 32'(port_out), 32'h81F0);
    check("R9", "unarmed rise port_oe", 32'(port_oe), 32'hC);

    // R10: latency of exactly three clock edges
    strobe_low(4'h5);
    @(negedge clk);
    bus_in = 4'h6;
    strb   = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R10", "no change after two edges", 32'(port_out), 32'h81F0);
    @(negedge clk);
    check("R10", "change after third edge", 32'(port_out), 32'h8160);
    check("R10", "enable after third edge", 32'(port_oe), 32'hE);
    idle(3);

    // R1: reset in the middle of a read
    port_in = 16'h7000;
    strobe_low(4'h3);
    check("R7", "read of port3 drives bus", 32'(bus_out), 32'h7);
    check("R7", "port3 released on capture", 32'(port_oe), 32'h6);
    @(negedge clk);
    rst  = 1'b1;
    strb = 1'b1;
    cs_n = 1'b1;
    idle(2);
    check("R1", "bus_oe cleared by reset", 32'(bus_oe), 32'h0);
    check("R1", "port_out cleared by reset", 32'(port_out), 32'h0);
    check("R1", "port_oe cleared by reset", 32'(port_oe), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule